// File: doc/BRIEF.md
# Nonvolatile Memory Program/Erase Control Register

This block is the 16-bit control and status register that sits between a CPU bus and the program/erase sequencer of an on-chip nonvolatile memory. Software writes an operation code, an erase/program selector and an enable bit, then sets a start bit. The register decodes the code into one command, passes that command to the memory back end through a start/done handshake, keeps the start bit set for a self-timed busy interval, and reports whether the last attempt went wrong.

Starting an operation is guarded. A start is accepted only when the enable bit is set in the same write and a two-word key was written to a separate key port in the two bus cycles directly before that write. A rejected start leaves the start bit clear and raises the error flag. A warm reset that lands in the middle of an operation aborts it and leaves the error flag set, so software can see that the last operation did not complete. Only a power-on reset clears that flag.

Top module: `nvmc_ctrl_reg`

## Requirements
- R1: After power-on reset the control readback is 0x0000, `be_start` is 0 and `be_cmd` is 0 (no command).
- R2: Readback layout: bit 0 start, bit 1 enable, bit 2 error, bit 7 erase select (1 = erase, 0 = program), bits 13:8 operation code. All other bits read 0.
- R3: A write to the control port with bit 0 set makes the start bit 1 only if bit 1 of the same write is 1 and the key port received `KEY_A` and then `KEY_B` in the two immediately preceding clock cycles. Otherwise the start bit stays 0, the error flag becomes 1, and the other fields take the written values.
- R4: Software cannot clear the start bit. While it is 1, every control-port write is ignored.
- R5: With erase select 1, codes decode as follows: 1010xx gives `be_cmd`=3 (boot region), 1001xx gives 4 (whole memory), 0101xx gives 5 (configuration region), 0100xx gives 6 (data EEPROM), 0011xx gives 7 (general region), and 011000, 011001 and 011010 give 2 (row erase) with `be_rows` 1, 2 and 4.
- R6: Erase select 0 with code 0001xx gives `be_cmd`=1 with `be_rows`=1. Every other combination is a no-operation: the start bit is 1 for exactly one cycle, `be_start` stays 0, and the error flag stays 0.
- R7: `be_start` is a single-cycle pulse, high in the cycle right after the accepted write. `be_cmd`, `be_rows` and `be_addr` hold steady while the start bit is 1, and `be_addr` equals `tbl_addr` as it was at the accepted write.
- R8: For a real command the start bit stays 1 for T cycles (`T_PROG`, `T_ROW` or `T_BULK` for row program, row erase and region erase), or longer if needed. It clears on the clock edge that samples `be_done` high, or at the end of the T cycles if `be_done` was seen earlier.
- R9: An accepted start clears the error flag. Software can clear the flag by writing 0 to bit 2 while no operation is active.
- R10: If `rst_n` is asserted while the start bit is 1, the operation is aborted (start 0, `be_cmd` 0) and the error flag reads 1. The flag survives `rst_n` and is cleared only by `por_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears every field including the error flag |
| rst_n | input | 1 | Warm reset, active low, asynchronous assert and synchronous release; must also be low while `por_n` is low |
| bus_wr | input | 1 | Bus write strobe, one write per cycle |
| bus_key_sel | input | 1 | 1 = write goes to the key port, 0 = write goes to the control register |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Control register readback |
| tbl_addr | input | ADDR_W | Row address from the external table pointer |
| be_start | output | 1 | One-cycle launch pulse to the memory back end |
| be_cmd | output | 3 | Command code for the back end, 0 when idle |
| be_rows | output | 3 | Row count for row commands, 0 for region erases |
| be_addr | output | ADDR_W | Address latched when the start was accepted |
| be_done | input | 1 | Completion pulse from the memory back end |

## Verification
The bench builds the block with busy intervals of 4, 6 and 9 cycles for row program, row erase and region erase. This brings every command class, the exact length of each busy window and a warm reset inside a region erase into reach within a few dozen cycles. The back-end model answers after a chosen latency. A short latency shows that the timer alone sets the busy length. A latency longer than the programmed interval shows that the busy window stretches until `be_done` arrives.

// File: rtl/nvmc_pkg.sv
package nvmc_pkg;

  typedef enum logic [2:0] {
    CMD_NONE       = 3'd0,
    CMD_PROG_ROW   = 3'd1,
    CMD_ERASE_ROWS = 3'd2,
    CMD_ERASE_BOOT = 3'd3,
    CMD_ERASE_ALL  = 3'd4,
    CMD_ERASE_CFG  = 3'd5,
    CMD_ERASE_DATA = 3'd6,
    CMD_ERASE_GEN  = 3'd7
  } nvm_cmd_e;

  typedef enum logic [1:0] {
    CLS_NOP  = 2'd0,
    CLS_PROG = 2'd1,
    CLS_ROW  = 2'd2,
    CLS_BULK = 2'd3
  } op_class_e;

  localparam int unsigned DATA_W  = 16;
  localparam int unsigned OP_W    = 6;
  localparam int unsigned GO_BIT  = 0;
  localparam int unsigned EN_BIT  = 1;
  localparam int unsigned ERR_BIT = 2;
  localparam int unsigned SEL_BIT = 7;
  localparam int unsigned OP_LSB  = 8;

endpackage

// File: rtl/nvmc_unlock.sv
module nvmc_unlock #(
  parameter logic [15:0] KEY_A = 16'h3C5A,
  parameter logic [15:0] KEY_B = 16'hA5C3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [15:0] key_data,
  output logic        armed
);

  logic stage_q, stage_d;
  logic armed_q, armed_d;

  // the first key opens a one-cycle window for the second key;
  // the second key opens a one-cycle window for the start write
  always_comb begin
    stage_d = key_wr && (key_data == KEY_A);
    armed_d = key_wr && (key_data == KEY_B) && stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      stage_q <= stage_d;
      armed_q <= armed_d;
    end
  end

  assign armed = armed_q;

  a_r3_armed_needs_key_pair: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> $past(key_wr && key_data == KEY_B));

  a_r3_arm_lasts_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> !armed_q);

endmodule

// File: rtl/nvmc_decode.sv
module nvmc_decode
  import nvmc_pkg::*;
(
  input  logic            erase_sel,
  input  logic [OP_W-1:0] op,
  output nvm_cmd_e        cmd,
  output op_class_e       cls,
  output logic [2:0]      rows
);

  always_comb begin
    cmd  = CMD_NONE;
    cls  = CLS_NOP;
    rows = 3'd0;
    if (erase_sel) begin
      unique case (op[5:2])
        4'b1010: begin cmd = CMD_ERASE_BOOT; cls = CLS_BULK; end
        4'b1001: begin cmd = CMD_ERASE_ALL;  cls = CLS_BULK; end
        4'b0101: begin cmd = CMD_ERASE_CFG;  cls = CLS_BULK; end
        4'b0100: begin cmd = CMD_ERASE_DATA; cls = CLS_BULK; end
        4'b0011: begin cmd = CMD_ERASE_GEN;  cls = CLS_BULK; end
        4'b0110: begin
          unique case (op[1:0])
            2'b00: begin cmd = CMD_ERASE_ROWS; cls = CLS_ROW; rows = 3'd1; end
            2'b01: begin cmd = CMD_ERASE_ROWS; cls = CLS_ROW; rows = 3'd2; end
            2'b10: begin cmd = CMD_ERASE_ROWS; cls = CLS_ROW; rows = 3'd4; end
            default: ;
          endcase
        end
        default: ;
      endcase
    end else if (op[5:2] == 4'b0001) begin
      cmd  = CMD_PROG_ROW;
      cls  = CLS_PROG;
      rows = 3'd1;
    end
  end

  always_comb begin
    a_r6_class_matches_cmd: assert ((cmd == CMD_NONE) == (cls == CLS_NOP));
  end

endmodule

// File: rtl/nvmc_timer.sv
module nvmc_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             skip_done,
  input  logic             done,
  output logic             complete
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             seen_q, seen_d;
  logic             cnt_last;

  assign cnt_last = (cnt_q <= CNT_W'(1));
  assign complete = active && cnt_last && (seen_q || done);

  always_comb begin
    cnt_d  = cnt_q;
    seen_d = seen_q;
    if (load) begin
      cnt_d  = load_val;
      seen_d = skip_done;
    end else if (active && !complete) begin
      if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
      seen_d = seen_q || done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
    end
  end

  a_r8_count_moves_down: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load && !complete && $past(active)) |=> (cnt_q <= $past(cnt_q)));

  a_r8_load_starts_window: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q != '0));

endmodule

// File: rtl/nvmc_ctrl_reg.sv
module nvmc_ctrl_reg
  import nvmc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned T_PROG = 64,
  parameter int unsigned T_ROW  = 256,
  parameter int unsigned T_BULK = 2048,
  parameter logic [15:0] KEY_A  = 16'h3C5A,
  parameter logic [15:0] KEY_B  = 16'hA5C3
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_key_sel,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic [ADDR_W-1:0] tbl_addr,
  output logic              be_start,
  output logic [2:0]        be_cmd,
  output logic [2:0]        be_rows,
  output logic [ADDR_W-1:0] be_addr,
  input  logic              be_done
);

  localparam int unsigned T_PR  = (T_PROG > T_ROW) ? T_PROG : T_ROW;
  localparam int unsigned T_MAX = (T_PR > T_BULK) ? T_PR : T_BULK;
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);

  // ---------------- bus decode ----------------
  logic ctl_wr, key_wr;
  logic unused_wdata;

  assign ctl_wr = bus_wr && !bus_key_sel;
  assign key_wr = bus_wr &&  bus_key_sel;
  assign unused_wdata = &{1'b0, bus_wdata[15:14], bus_wdata[6:3]};

  // ---------------- unlock window ----------------
  logic armed;

  nvmc_unlock #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_data (bus_wdata),
    .armed    (armed)
  );

  // ---------------- command decode ----------------
  nvm_cmd_e        dec_cmd;
  op_class_e       dec_cls;
  logic [2:0]      dec_rows;
  logic [OP_W-1:0] wr_op;

  assign wr_op = bus_wdata[OP_LSB +: OP_W];

  nvmc_decode u_decode (
    .erase_sel (bus_wdata[SEL_BIT]),
    .op        (wr_op),
    .cmd       (dec_cmd),
    .cls       (dec_cls),
    .rows      (dec_rows)
  );

  // ---------------- registers ----------------
  logic            go_q, go_d;
  logic            en_q, en_d;
  logic            sel_q, sel_d;
  logic [OP_W-1:0] op_q, op_d;
  nvm_cmd_e        cmd_q, cmd_d;
  logic [2:0]      rows_q, rows_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic            launch_q, launch_d;
  logic            err_q, err_d;
  logic            shadow_q, shadow_d;

  logic            set_try, accept, reg_wr_en;
  logic            tmr_complete;
  logic [CNT_W-1:0] load_val;

  assign set_try   = ctl_wr && bus_wdata[GO_BIT] && !go_q;
  assign accept    = set_try && bus_wdata[EN_BIT] && armed;
  assign reg_wr_en = ctl_wr && !go_q;

  always_comb begin
    unique case (dec_cls)
      CLS_PROG: load_val = CNT_W'(T_PROG);
      CLS_ROW:  load_val = CNT_W'(T_ROW);
      CLS_BULK: load_val = CNT_W'(T_BULK);
      default:  load_val = CNT_W'(1);
    endcase
  end

  nvmc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (go_q),
    .load      (accept),
    .load_val  (load_val),
    .skip_done (dec_cls == CLS_NOP),
    .done      (be_done),
    .complete  (tmr_complete)
  );

  // next state: field updates, start acceptance, busy hold
  always_comb begin
    en_d     = en_q;
    sel_d    = sel_q;
    op_d     = op_q;
    cmd_d    = cmd_q;
    rows_d   = rows_q;
    addr_d   = addr_q;
    launch_d = 1'b0;
    go_d     = go_q && !tmr_complete;
    if (reg_wr_en) begin
      en_d  = bus_wdata[EN_BIT];
      sel_d = bus_wdata[SEL_BIT];
      op_d  = wr_op;
    end
    if (accept) begin
      go_d     = 1'b1;
      cmd_d    = dec_cmd;
      rows_d   = dec_rows;
      addr_d   = tbl_addr;
      launch_d = (dec_cmd != CMD_NONE);
    end else if (go_q && tmr_complete) begin
      cmd_d  = CMD_NONE;
      rows_d = 3'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q     <= 1'b0;
      en_q     <= 1'b0;
      sel_q    <= 1'b0;
      op_q     <= '0;
      cmd_q    <= CMD_NONE;
      rows_q   <= 3'd0;
      addr_q   <= '0;
      launch_q <= 1'b0;
    end else begin
      go_q     <= go_d;
      en_q     <= en_d;
      sel_q    <= sel_d;
      op_q     <= op_d;
      cmd_q    <= cmd_d;
      rows_q   <= rows_d;
      addr_q   <= addr_d;
      launch_q <= launch_d;
    end
  end

  // error flag lives in the power-on domain so a warm reset cannot hide an abort
  always_comb begin
    shadow_d = rst_n ? go_d : 1'b0;
    if (!rst_n)                 err_d = err_q || shadow_q;
    else if (set_try && !accept) err_d = 1'b1;
    else if (accept)            err_d = 1'b0;
    else if (reg_wr_en)         err_d = bus_wdata[ERR_BIT];
    else                        err_d = err_q;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      err_q    <= 1'b0;
      shadow_q <= 1'b0;
    end else begin
      err_q    <= err_d;
      shadow_q <= shadow_d;
    end
  end

  // ---------------- outputs ----------------
  always_comb begin
    bus_rdata                     = '0;
    bus_rdata[GO_BIT]             = go_q;
    bus_rdata[EN_BIT]             = en_q;
    bus_rdata[ERR_BIT]            = err_q;
    bus_rdata[SEL_BIT]            = sel_q;
    bus_rdata[OP_LSB +: OP_W]     = op_q;
  end

  assign be_start = launch_q;
  assign be_cmd   = cmd_q;
  assign be_rows  = rows_q;
  assign be_addr  = addr_q;

  // ---------------- assertions ----------------
  a_r3_rise_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go_q) |-> $past(armed && ctl_wr && bus_wdata[EN_BIT]));

  a_r4_fall_only_on_complete: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(go_q) |-> $past(tmr_complete));

  a_r7_start_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    be_start |=> !be_start);

  a_r7_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    be_start |-> (go_q && be_cmd != 3'd0));

  a_r7_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && $past(go_q)) |-> ($stable(be_cmd) && $stable(be_addr) && $stable(be_rows)));

  a_r10_abort_flags_error: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_n && shadow_q) |=> err_q);

endmodule

// File: tb/tb_nvmc_ctrl_reg.sv
module tb_nvmc_ctrl_reg;

  localparam int CLK_PERIOD = 10;
  localparam int TP = 4;
  localparam int TR = 6;
  localparam int TB = 9;
  localparam logic [15:0] KA = 16'h3C5A;
  localparam logic [15:0] KB = 16'hA5C3;

  logic        clk = 1'b0;
  logic        por_n, rst_n;
  logic        bus_wr, bus_key_sel;
  logic [15:0] bus_wdata, bus_rdata;
  logic [15:0] tbl_addr;
  logic        be_start;
  logic [2:0]  be_cmd, be_rows;
  logic [15:0] be_addr;
  logic        be_done;

  int checks = 0;
  int failures = 0;
  int dl = 2;
  int done_cnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvmc_ctrl_reg #(.ADDR_W(16), .T_PROG(TP), .T_ROW(TR), .T_BULK(TB),
                  .KEY_A(KA), .KEY_B(KB)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_key_sel(bus_key_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tbl_addr(tbl_addr), .be_start(be_start), .be_cmd(be_cmd),
    .be_rows(be_rows), .be_addr(be_addr), .be_done(be_done));

  // back-end model: answers dl cycles after it sees the launch pulse
  always @(negedge clk) begin
    be_done = 1'b0;
    if (be_start) done_cnt = dl;
    else if (done_cnt > 0) begin
      done_cnt = done_cnt - 1;
      if (done_cnt == 0) be_done = 1'b1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_cycle(input logic ks, input logic [15:0] d);
    bus_wr = 1'b1; bus_key_sel = ks; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_key_sel = 1'b0; bus_wdata = 16'h0000;
  endtask

  task automatic keyed_write(input logic [15:0] d);
    wr_cycle(1'b1, KA);
    wr_cycle(1'b1, KB);
    wr_cycle(1'b0, d);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (bus_rdata[0] && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [15:0] ctl(input bit go, input bit en, input bit err,
                                      input bit sel, input logic [5:0] op);
    return {2'b00, op, sel, 4'b0000, err, en, go};
  endfunction

  // vector: {sel, op[5:0], cmd[2:0], rows[2:0], class[1:0]}  class 0 nop,1 prog,2 row,3 bulk
  localparam int NV = 14;
  localparam logic [14:0] VEC [NV] = '{
    {1'b0, 6'b000100, 3'd1, 3'd1, 2'd1},   // R6 program row
    {1'b0, 6'b000111, 3'd1, 3'd1, 2'd1},   // R6 program row, low bits don't care
    {1'b1, 6'b011000, 3'd2, 3'd1, 2'd2},   // R5 one row
    {1'b1, 6'b011001, 3'd2, 3'd2, 2'd2},   // R5 two rows
    {1'b1, 6'b011010, 3'd2, 3'd4, 2'd2},   // R5 four rows
    {1'b1, 6'b101011, 3'd3, 3'd0, 2'd3},   // R5 boot region
    {1'b1, 6'b100100, 3'd4, 3'd0, 2'd3},   // R5 whole memory
    {1'b1, 6'b010110, 3'd5, 3'd0, 2'd3},   // R5 configuration region
    {1'b1, 6'b010001, 3'd6, 3'd0, 2'd3},   // R5 data EEPROM
    {1'b1, 6'b001111, 3'd7, 3'd0, 2'd3},   // R5 general region
    {1'b1, 6'b011011, 3'd0, 3'd0, 2'd0},   // R6 unlisted row code
    {1'b0, 6'b011000, 3'd0, 3'd0, 2'd0},   // R6 erase code with program select
    {1'b1, 6'b000100, 3'd0, 3'd0, 2'd0},   // R6 program code with erase select
    {1'b0, 6'b101000, 3'd0, 3'd0, 2'd0}    // R6 boot code with program select
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    por_n = 1'b0; rst_n = 1'b0;
    bus_wr = 1'b0; bus_key_sel = 1'b0; bus_wdata = 16'h0; tbl_addr = 16'h0;
    be_done = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 readback", bus_rdata, 16'h0000);
    check("R1 be_start", be_start, 1'b0);
    check("R1 be_cmd", be_cmd, 3'd0);

    // R2 field layout and unimplemented bits
    wr_cycle(1'b0, 16'hFFFE);
    check("R2 all-ones write readback", bus_rdata, 16'h3F86);
    wr_cycle(1'b0, ctl(0, 1, 0, 1, 6'h2A));
    check("R2 field write readback / R9 sw clears error", bus_rdata, 16'h2A82);

    // R3 start without key
    wr_cycle(1'b0, ctl(1, 1, 0, 1, 6'b011000));
    check("R3 no key: start 0, error 1", bus_rdata, {ctl(0, 1, 1, 1, 6'b011000)});
    check("R3 no key: no launch", be_start, 1'b0);
    wr_cycle(1'b0, 16'h0000);
    // R3 key present but enable 0
    keyed_write(ctl(1, 0, 0, 0, 6'b000100));
    check("R3 enable 0: rejected", bus_rdata, ctl(0, 0, 1, 0, 6'b000100));
    wr_cycle(1'b0, 16'h0000);
    // R3 keys in wrong order
    wr_cycle(1'b1, KB);
    wr_cycle(1'b1, KA);
    wr_cycle(1'b0, ctl(1, 1, 0, 0, 6'b000100));
    check("R3 key order swapped: rejected", bus_rdata, ctl(0, 1, 1, 0, 6'b000100));
    // R3 gap between key and start; error left set to test R9 clear-on-start
    wr_cycle(1'b1, KA);
    wr_cycle(1'b1, KB);
    @(negedge clk);
    wr_cycle(1'b0, ctl(1, 1, 0, 0, 6'b000100));
    check("R3 gap after key: rejected", bus_rdata, ctl(0, 1, 1, 0, 6'b000100));

    // vector table: R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic        sel;
      logic [5:0]  op;
      logic [2:0]  ecmd, erows;
      logic [1:0]  cls;
      int          exp_busy;
      {sel, op, ecmd, erows, cls} = VEC[i];
      tbl_addr = 16'h1000 + 16'(i * 16'h0111);
      case (cls)
        2'd1: exp_busy = (TP > dl + 1) ? TP : dl + 1;
        2'd2: exp_busy = (TR > dl + 1) ? TR : dl + 1;
        2'd3: exp_busy = (TB > dl + 1) ? TB : dl + 1;
        default: exp_busy = 1;
      endcase
      keyed_write(ctl(1, 1, 0, sel, op));
      check($sformatf("R7 vec%0d be_start", i), be_start, (cls != 2'd0));
      check($sformatf("R5 vec%0d be_cmd", i), be_cmd, ecmd);
      check($sformatf("R5 vec%0d be_rows", i), be_rows, erows);
      if (cls != 2'd0) check($sformatf("R7 vec%0d be_addr", i), be_addr, tbl_addr);
      check($sformatf("R9 vec%0d error cleared by start", i), bus_rdata[2], 1'b0);
      tbl_addr = 16'hDEAD;
      busy_len(n);
      check($sformatf("R8 vec%0d busy cycles", i), n, exp_busy);
      check($sformatf("R6 vec%0d readback after", i), bus_rdata, ctl(0, 1, 0, sel, op));
      check($sformatf("R7 vec%0d be_cmd idle", i), be_cmd, 3'd0);
    end

    // R4 writes while busy are ignored
    keyed_write(ctl(1, 1, 0, 0, 6'b000100));
    wr_cycle(1'b0, 16'h0004);
    check("R4 busy write ignored", bus_rdata, ctl(1, 1, 0, 0, 6'b000100));
    check("R4 command held", be_cmd, 3'd1);
    busy_len(n);
    check("R4 remaining busy", n, TP - 1);

    // R8 late done stretches the window
    dl = 12;
    keyed_write(ctl(1, 1, 0, 0, 6'b000101));
    busy_len(n);
    check("R8 late done busy cycles", n, 13);
    dl = 2;
    repeat (3) @(negedge clk);

    // R10 warm reset during a region erase
    keyed_write(ctl(1, 1, 0, 1, 6'b100100));
    repeat (3) @(negedge clk);
    check("R10 still busy before reset", bus_rdata[0], 1'b1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 aborted, error set", bus_rdata, 16'h0004);
    check("R10 command dropped", be_cmd, 3'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 error survives warm reset", bus_rdata, 16'h0004);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle warm reset keeps error", bus_rdata, 16'h0004);
    por_n = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    check("R10 R1 power-on clears error", bus_rdata, 16'h0000);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule